// File: doc/BRIEF.md
# SDRAM Power-Up Initialization Sequencer

This block brings an SDRAM device from power-up to a usable state without software help. After a synchronous reset it enables the memory controller, holds refresh off and waits a power-up delay of about 200 microseconds. The delay is counted in clock cycles derived from a clock-frequency parameter. It then steps through a fixed command program: one precharge-all, eight auto-refreshes and one mode-register set. Every command is followed by an idle slot. The complete wait-plus-program pass runs twice, because some devices only settle after a second initialization.

While a pass is running, the block drives the mode-register data byte that the controller places on the address lines when the mode-register set goes out. The byte is worked out from three static strap inputs: a 2-bit latency field, a clock-speed select and a bus-width select. A nonzero direct byte overrides the computed value. Each pass ends with a one-cycle restore step in which refresh is enabled again and the mode byte and command return to zero. The final restore also raises a single-cycle done pulse. From then on the block holds the controller enabled with refresh on.

Top module: `sdram_pwrup_seq`

## Requirements
- R1: While reset is high and in the first cycle after it falls, every output is zero: `cmd`=0, `ctrl_en`=0, `refresh_dis`=0, `mode_byte`=0, `done`=0.
- R2: After that idle cycle, each pass opens with exactly WAIT_CYC = CLK_KHZ*WAIT_US/1000 cycles in which `ctrl_en`=1, `refresh_dis`=1 and `cmd`=0.
- R3: Command codes on `cmd` are 3=precharge-all, 2=auto-refresh, 1=mode-register set and 0=no-operation. Each pass issues 20 slots in this order: 3,0, then eight pairs 2,0, then 1,0.
- R4: Slot issues are exactly GAP (default 5) cycles apart. Each issue lasts one cycle, and `cmd` is 0 in every other cycle.
- R5: Latency 2 is decoded as field==0 when `fast_clk`=1 (100 MHz) and as field==1 when `fast_clk`=0 (50 MHz); every other field value means latency 3. With `wide_bus`=1 (32-bit), `mode_byte` is 0x40 for latency 2 and 0x60 for latency 3.
- R6: With `wide_bus`=0 (16-bit), the computed byte is halved: 0x20 for latency 2 and 0x30 for latency 3.
- R7: A nonzero `mode_override` replaces the computed byte unchanged.
- R8: During the wait and all command slots, `refresh_dis`=1 and `mode_byte` carries the selected byte. Each pass ends with one restore cycle with `ctrl_en`=1, `refresh_dis`=0, `mode_byte`=0 and `cmd`=0.
- R9: Exactly two passes run. `done` is high only in the restore cycle of the second pass. Afterwards the outputs stay at `ctrl_en`=1 with all others 0.
- R10: Reset asserted in the middle of a sequence returns the block to the idle state. After release the block restarts from the first pass.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cas_field | input | 2 | Configured latency field (static) |
| fast_clk | input | 1 | 1 = 100 MHz clock, 0 = 50 MHz (static) |
| wide_bus | input | 1 | 1 = 32-bit data bus, 0 = 16-bit (static) |
| mode_override | input | 8 | Direct mode byte; nonzero replaces the computed value |
| mode_byte | output | 8 | Mode-register data for the mode-register set |
| cmd | output | 3 | Command code issued to the device |
| refresh_dis | output | 1 | Auto-refresh disabled |
| ctrl_en | output | 1 | Memory controller enabled |
| done | output | 1 | One-cycle pulse when initialization finishes |

## Verification
The latency decode is the easiest part to get wrong. The same field value means latency 2 at one clock speed and latency 3 at the other, so a decoder that ignores the speed select, or halves the byte on the wrong bus width, would emit 0x60 where 0x40 or 0x30 belongs. The bench therefore walks through both speeds, both widths, several field values and an override. Its cycle-accurate model would expose an off-by-one in the wait or gap counters as a command issued one cycle early. The same model would catch a missing restore cycle between passes, or a single-pass design raising done about a hundred cycles too soon. A reset in the middle of the second pass checks that the pass count is cleared; a design that kept it would run only one pass after the restart.

// File: rtl/sdram_init_pkg.sv
package sdram_init_pkg;

    typedef enum logic [2:0] {
        CMD_NOP  = 3'd0,
        CMD_MRS  = 3'd1,
        CMD_REF  = 3'd2,
        CMD_PALL = 3'd3
    } sdram_cmd_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_WAIT,
        ST_ISSUE,
        ST_GAP,
        ST_RESTORE,
        ST_HOLD
    } seq_state_e;

    typedef struct packed {
        logic       ctrl_en;
        logic       refresh_dis;
        logic [7:0] mode;
        sdram_cmd_e cmd;
        logic       done;
    } seq_out_t;

    // Command carried by slot s of one pass: even slots issue, odd slots idle.
    function automatic sdram_cmd_e slot_cmd(int unsigned s, int unsigned nref);
        if ((s % 2) != 0) return CMD_NOP;
        if (s == 0)        return CMD_PALL;
        if ((s / 2) <= nref) return CMD_REF;
        return CMD_MRS;
    endfunction

    // Latency-2 decode depends on the clock-speed select.
    function automatic logic latency_is_two(logic [1:0] field, logic fast);
        return fast ? (field == 2'd0) : (field == 2'd1);
    endfunction

    function automatic logic [7:0] computed_mode(logic [1:0] field, logic fast, logic wide);
        logic [7:0] v;
        v = latency_is_two(field, fast) ? 8'h40 : 8'h60;
        if (!wide) v = v >> 1;
        return v;
    endfunction

endpackage

// File: rtl/sdram_mode_calc.sv
module sdram_mode_calc
    import sdram_init_pkg::*;
(
    input  logic [1:0] cas_field,
    input  logic       fast_clk,
    input  logic       wide_bus,
    input  logic [7:0] mode_override,
    output logic [7:0] mode_byte
);
    logic [7:0] derived;

    always_comb begin
        derived   = computed_mode(cas_field, fast_clk, wide_bus);
        mode_byte = (mode_override != 8'h00) ? mode_override : derived;
    end
endmodule

// File: rtl/sdram_dcount.sv
module sdram_dcount #(
    parameter int unsigned W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic         zero
);
    logic [W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst)                cnt_q <= '0;
        else if (load)          cnt_q <= load_val;
        else if (cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
    end

    assign zero = (cnt_q == '0);
endmodule

// File: rtl/sdram_slot_rom.sv
module sdram_slot_rom
    import sdram_init_pkg::*;
#(
    parameter int unsigned N_REF  = 8,
    parameter int unsigned N_SLOT = 2 * (N_REF + 2),
    parameter int unsigned SLOT_W = $clog2(N_SLOT)
) (
    input  logic [SLOT_W-1:0] slot,
    output sdram_cmd_e        code,
    output logic              last
);
    sdram_cmd_e table_q [N_SLOT];

    for (genvar g = 0; g < N_SLOT; g++) begin : g_slot
        assign table_q[g] = slot_cmd(g, N_REF);
    end

    always_comb begin
        code = CMD_NOP;
        if (int'(slot) < N_SLOT) code = table_q[slot];
    end

    assign last = (slot == SLOT_W'(N_SLOT - 1));
endmodule

// File: rtl/sdram_pwrup_seq.sv
module sdram_pwrup_seq
    import sdram_init_pkg::*;
#(
    parameter int unsigned CLK_KHZ = 125000,
    parameter int unsigned WAIT_US = 200,
    parameter int unsigned GAP     = 5,
    parameter int unsigned N_REF   = 8,
    parameter int unsigned N_PASS  = 2
) (
    input  logic       clk,
    input  logic       rst,
    input  logic [1:0] cas_field,
    input  logic       fast_clk,
    input  logic       wide_bus,
    input  logic [7:0] mode_override,
    output logic [7:0] mode_byte,
    output logic [2:0] cmd,
    output logic       refresh_dis,
    output logic       ctrl_en,
    output logic       done
);
    localparam int unsigned WAIT_RAW = (CLK_KHZ * WAIT_US) / 1000;
    localparam int unsigned WAIT_CYC = (WAIT_RAW < 1) ? 1 : WAIT_RAW;
    localparam int unsigned GAP_EFF  = (GAP < 2) ? 2 : GAP;
    localparam int unsigned N_SLOT   = 2 * (N_REF + 2);
    localparam int unsigned SLOT_W   = $clog2(N_SLOT);
    localparam int unsigned PASS_W   = (N_PASS > 1) ? $clog2(N_PASS) : 1;
    localparam int unsigned WCW      = $clog2(WAIT_CYC + 1);
    localparam int unsigned GCW      = $clog2(GAP_EFF + 1);

    seq_state_e        state_q, state_d;
    logic [SLOT_W-1:0] slot_q, slot_d;
    logic [PASS_W-1:0] pass_q, pass_d;

    logic       wait_load, wait_zero;
    logic       gap_load, gap_zero;
    logic [7:0] sel_mode;
    sdram_cmd_e slot_code;
    logic       slot_last;
    logic       last_pass;
    seq_out_t   out_s;

    sdram_mode_calc u_mode (
        .cas_field     (cas_field),
        .fast_clk      (fast_clk),
        .wide_bus      (wide_bus),
        .mode_override (mode_override),
        .mode_byte     (sel_mode)
    );

    sdram_dcount #(.W(WCW)) u_wait (
        .clk      (clk),
        .rst      (rst),
        .load     (wait_load),
        .load_val (WCW'(WAIT_CYC - 1)),
        .zero     (wait_zero)
    );

    sdram_dcount #(.W(GCW)) u_gap (
        .clk      (clk),
        .rst      (rst),
        .load     (gap_load),
        .load_val (GCW'(GAP_EFF - 2)),
        .zero     (gap_zero)
    );

    sdram_slot_rom #(.N_REF(N_REF), .N_SLOT(N_SLOT), .SLOT_W(SLOT_W)) u_rom (
        .slot (slot_q),
        .code (slot_code),
        .last (slot_last)
    );

    assign last_pass = (pass_q == PASS_W'(N_PASS - 1));
    assign wait_load = (state_q == ST_IDLE) || ((state_q == ST_RESTORE) && !last_pass);
    assign gap_load  = (state_q == ST_ISSUE);

    always_comb begin
        state_d = state_q;
        slot_d  = slot_q;
        pass_d  = pass_q;
        unique case (state_q)
            ST_IDLE:    state_d = ST_WAIT;
            ST_WAIT: begin
                if (wait_zero) begin
                    state_d = ST_ISSUE;
                    slot_d  = '0;
                end
            end
            ST_ISSUE:   state_d = ST_GAP;
            ST_GAP: begin
                if (gap_zero) begin
                    if (slot_last) begin
                        state_d = ST_RESTORE;
                    end else begin
                        state_d = ST_ISSUE;
                        slot_d  = slot_q + 1'b1;
                    end
                end
            end
            ST_RESTORE: begin
                if (last_pass) begin
                    state_d = ST_HOLD;
                end else begin
                    state_d = ST_WAIT;
                    pass_d  = pass_q + 1'b1;
                end
            end
            ST_HOLD:    state_d = ST_HOLD;
            default:    state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            slot_q  <= '0;
            pass_q  <= '0;
        end else begin
            state_q <= state_d;
            slot_q  <= slot_d;
            pass_q  <= pass_d;
        end
    end

    always_comb begin
        out_s = '{ctrl_en: 1'b0, refresh_dis: 1'b0, mode: 8'h00, cmd: CMD_NOP, done: 1'b0};
        unique case (state_q)
            ST_WAIT, ST_GAP: begin
                out_s.ctrl_en     = 1'b1;
                out_s.refresh_dis = 1'b1;
                out_s.mode        = sel_mode;
            end
            ST_ISSUE: begin
                out_s.ctrl_en     = 1'b1;
                out_s.refresh_dis = 1'b1;
                out_s.mode        = sel_mode;
                out_s.cmd         = slot_code;
            end
            ST_RESTORE: begin
                out_s.ctrl_en = 1'b1;
                out_s.done    = last_pass;
            end
            ST_HOLD:    out_s.ctrl_en = 1'b1;
            default: ;
        endcase
    end

    assign mode_byte   = out_s.mode;
    assign cmd         = out_s.cmd;
    assign refresh_dis = out_s.refresh_dis;
    assign ctrl_en     = out_s.ctrl_en;
    assign done        = out_s.done;

endmodule

// File: rtl/sdram_pwrup_seq_chk.sv
module sdram_pwrup_seq_chk #(
    parameter int unsigned GAP = 5
) (
    input logic       clk,
    input logic       rst,
    input logic [7:0] mode_byte,
    input logic [2:0] cmd,
    input logic       refresh_dis,
    input logic       ctrl_en,
    input logic       done
);
    logic [7:0] since_q;
    logic       seen_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            since_q <= '0;
            seen_q  <= 1'b0;
        end else if (cmd != 3'd0) begin
            since_q <= '0;
            seen_q  <= 1'b1;
        end else if (since_q != 8'hFF) begin
            since_q <= since_q + 1'b1;
        end
    end

    assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (rst)
        !ctrl_en |-> (cmd == 3'd0 && !refresh_dis && mode_byte == 8'h00 && !done));

    assert_cmd_spacing_R4: assert property (@(posedge clk) disable iff (rst)
        (cmd != 3'd0 && seen_q) |-> (int'(since_q) >= int'(GAP) - 1));

    assert_single_issue_R4: assert property (@(posedge clk) disable iff (rst)
        (cmd != 3'd0) |=> (cmd == 3'd0));

    assert_cmd_under_init_R8: assert property (@(posedge clk) disable iff (rst)
        (cmd != 3'd0) |-> (refresh_dis && ctrl_en));

    assert_mode_gated_R8: assert property (@(posedge clk) disable iff (rst)
        (mode_byte != 8'h00) |-> refresh_dis);

    assert_done_state_R9: assert property (@(posedge clk) disable iff (rst)
        done |-> (ctrl_en && !refresh_dis && cmd == 3'd0));

    assert_done_pulse_R9: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);
endmodule

bind sdram_pwrup_seq sdram_pwrup_seq_chk #(.GAP(GAP)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .mode_byte   (mode_byte),
    .cmd         (cmd),
    .refresh_dis (refresh_dis),
    .ctrl_en     (ctrl_en),
    .done        (done)
);

// File: tb/tb_sdram_pwrup_seq.sv
module tb_sdram_pwrup_seq;
    localparam int CLK_KHZ  = 50;
    localparam int WAIT_US  = 200;
    localparam int GAP      = 5;
    localparam int WAIT_CYC = CLK_KHZ * WAIT_US / 1000;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [1:0] cas_field = 2'd0;
    logic       fast_clk = 1'b1;
    logic       wide_bus = 1'b1;
    logic [7:0] mode_override = 8'h00;
    logic [7:0] mode_byte;
    logic [2:0] cmd;
    logic       refresh_dis, ctrl_en, done;

    int n_cmp = 0;
    int n_bad = 0;

    // entry layout: {done, ctrl_en, refresh_dis, mode[7:0], cmd[2:0]}
    logic [13:0] expq[$];

    always #4 clk = ~clk;

    sdram_pwrup_seq #(.CLK_KHZ(CLK_KHZ), .WAIT_US(WAIT_US), .GAP(GAP)) dut (
        .clk(clk), .rst(rst), .cas_field(cas_field), .fast_clk(fast_clk),
        .wide_bus(wide_bus), .mode_override(mode_override), .mode_byte(mode_byte),
        .cmd(cmd), .refresh_dis(refresh_dis), .ctrl_en(ctrl_en), .done(done)
    );

    initial begin
        repeat (200000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: run did not finish, actual=hung expected=finished");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    function automatic logic [13:0] pack_exp(int c, bit en, bit rd, logic [7:0] m, bit dn);
        return {dn, en, rd, m, 3'(c)};
    endfunction

    task automatic build(input logic [7:0] mb);
        expq.delete();
        expq.push_back(pack_exp(0, 0, 0, 8'h00, 0));                // R1 idle
        for (int p = 0; p < 2; p++) begin
            for (int w = 0; w < WAIT_CYC; w++) expq.push_back(pack_exp(0, 1, 1, mb, 0));
            for (int s = 0; s < 20; s++) begin
                int c;
                if (s % 2 == 1)  c = 0;
                else if (s == 0) c = 3;
                else if (s == 18) c = 1;
                else             c = 2;
                expq.push_back(pack_exp(c, 1, 1, mb, 0));
                for (int g = 0; g < GAP - 1; g++) expq.push_back(pack_exp(0, 1, 1, mb, 0));
            end
            expq.push_back(pack_exp(0, 1, 0, 8'h00, p == 1));
        end
        for (int h = 0; h < 8; h++) expq.push_back(pack_exp(0, 1, 0, 8'h00, 0));
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        @(negedge clk);
        rst = 1'b0;
    endtask

    // compares up to limit cycles of the expected sequence, starting at the release edge
    task automatic run_seq(input int limit);
        int last_issue = -1000;
        int idx = 0;
        while (expq.size() > 0 && idx < limit) begin
            logic [13:0] e;
            logic [13:0] a;
            if (idx > 0) @(negedge clk);
            #1;
            e = expq.pop_front();
            a = {done, ctrl_en, refresh_dis, mode_byte, cmd};
            n_cmp++;
            if (a !== e) begin
                n_bad++;
                if (idx == 0)
                    $display("FAIL R1 idle cycle %0d: actual=%h expected=%h", idx, a, e);
                else if (a[2:0] !== e[2:0])
                    $display("FAIL R3 cmd cycle %0d: actual=%0d expected=%0d", idx, a[2:0], e[2:0]);
                else if (a[12] !== e[12])
                    $display("FAIL R2 ctrl_en cycle %0d: actual=%b expected=%b", idx, a[12], e[12]);
                else if (a[11] !== e[11])
                    $display("FAIL R8 refresh_dis cycle %0d: actual=%b expected=%b", idx, a[11], e[11]);
                else if (a[10:3] !== e[10:3])
                    $display("FAIL R5 mode cycle %0d: actual=%h expected=%h", idx, a[10:3], e[10:3]);
                else
                    $display("FAIL R9 done cycle %0d: actual=%b expected=%b", idx, a[13], e[13]);
            end
            if (cmd != 3'd0) begin
                if (last_issue >= 0) begin
                    n_cmp++;
                    if (idx - last_issue < GAP) begin
                        n_bad++;
                        $display("FAIL R4 spacing: actual=%0d expected>=%0d", idx - last_issue, GAP);
                    end
                end
                last_issue = idx;
            end
            idx++;
        end
    endtask

    task automatic run_cfg(input logic [1:0] cf, input bit fc, input bit wb,
                           input logic [7:0] ovr, input logic [7:0] exp_mb, input string tag);
        cas_field = cf; fast_clk = fc; wide_bus = wb; mode_override = ovr;
        do_reset();
        #1;
        n_cmp++;
        if (cmd !== 3'd0 || ctrl_en !== 1'b0 || done !== 1'b0) begin
            n_bad++;
            $display("FAIL R1 reset outputs: actual=%0d/%b/%b expected=0/0/0", cmd, ctrl_en, done);
        end
        repeat (2) @(negedge clk);
        #1;
        n_cmp++;
        if (mode_byte !== exp_mb) begin
            n_bad++;
            $display("FAIL %s mode byte: actual=%h expected=%h", tag, mode_byte, exp_mb);
        end
        build(exp_mb);
        do_reset();
        run_seq(1 << 30);
    endtask

    initial begin
        run_cfg(2'd0, 1'b1, 1'b1, 8'h00, 8'h40, "R5");  // 100 MHz field 0 -> CL2
        run_cfg(2'd1, 1'b1, 1'b1, 8'h00, 8'h60, "R5");  // 100 MHz field 1 -> CL3
        run_cfg(2'd1, 1'b0, 1'b1, 8'h00, 8'h40, "R5");  // 50 MHz field 1 -> CL2
        run_cfg(2'd0, 1'b0, 1'b1, 8'h00, 8'h60, "R5");  // 50 MHz field 0 -> CL3
        run_cfg(2'd2, 1'b1, 1'b0, 8'h00, 8'h30, "R6");
        run_cfg(2'd0, 1'b1, 1'b0, 8'h00, 8'h20, "R6");
        run_cfg(2'd1, 1'b0, 1'b0, 8'h00, 8'h20, "R6");
        run_cfg(2'd3, 1'b0, 1'b0, 8'h00, 8'h30, "R6");
        run_cfg(2'd0, 1'b1, 1'b1, 8'h35, 8'h35, "R7");
        // R10: abort inside the second pass, then expect a full two-pass restart
        cas_field = 2'd2; fast_clk = 1'b0; wide_bus = 1'b0; mode_override = 8'h00;
        build(8'h30);
        do_reset();
        run_seq(150);
        build(8'h30);
        do_reset();
        #1;
        n_cmp++;
        if (ctrl_en !== 1'b0 || refresh_dis !== 1'b0) begin
            n_bad++;
            $display("FAIL R10 mid-run reset: actual=%b%b expected=00", ctrl_en, refresh_dis);
        end
        run_seq(1 << 30);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule